// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block is the slave side of a four-wire serial link. A host drives a chip select, a serial clock and a data line. The block samples all three with a faster system clock and assembles 16-bit words, most significant bit first. Each completed word is split into a 4-bit command field (the first four bits received) and a 12-bit data field (the last twelve). Both fields go to downstream register logic together with a one-cycle valid strobe.

Clock polarity and phase follow the usual SPI mode numbering. A separate DSP setting forces capture on the rising clock edge whatever the mode. A frame can close in one of two ways: when chip select is released, or on the sixteenth capture edge. A frame that is too short is discarded. The serial output always shows the top bit of the shift register, so several receivers can be chained. Each one passes on the bits it held before the current frame.

Top module: `spi_frame_rx`

## Requirements
- R1: A completed frame presents its first four received bits on `frm_cmd[3:0]` (first bit at bit 3) and its last twelve on `frm_data[11:0]` (last bit at bit 0).
- R2: With `cfg_dsp` low, data is captured on the rising serial clock edge when `cfg_cpol` equals `cfg_cpha`, and on the falling edge otherwise.
- R3: With `cfg_dsp` high, data is captured on the rising serial clock edge for every polarity and phase setting.
- R4: With `cfg_end_mode` = 0, no strobe is issued while chip select stays low. One strobe follows the release of chip select if at least 16 bits were captured, and it carries the last 16 bits received.
- R5: With `cfg_end_mode` = 1, a strobe follows every sixteenth capture edge without waiting for chip select. The bit count then restarts, so a 32-bit burst yields two frames, and releasing chip select adds no strobe.
- R6: Releasing chip select after fewer than 16 captured bits produces no strobe, and the bit count restarts at zero for the next frame.
- R7: `dout` equals the top bit of the 16-bit shift register. During a frame that follows frame X, after k capture edges (1 ≤ k ≤ 15), `dout` shows bit 15−k of X.
- R8: `frm_valid` is high for exactly one system clock cycle per frame.
- R9: After reset, `frm_valid` and `dout` are 0 and the bit count is zero.
- R10: Serial clock edges while chip select is high neither shift data nor advance the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Serial clock phase |
| cfg_dsp | input | 1 | Force rising-edge capture |
| cfg_end_mode | input | 1 | 0: frame ends at chip select release; 1: frame ends on sixteenth capture edge |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data in |
| dout | output | 1 | Shift register top bit, for chaining |
| frm_valid | output | 1 | One-cycle frame strobe |
| frm_cmd | output | 4 | Command field of the last frame |
| frm_data | output | 12 | Data field of the last frame |

## Verification
The bench runs all sixteen combinations of polarity, phase, DSP setting and end mode. It expects wrong-edge capture to show up as words that are off by one bit position. It sends short frames and expects no strobe: a design that strobes on them would give a spurious count, and one that keeps a stale count would mis-frame the word after. It sends 32-bit bursts to tell a saturating count from a wrapping one: the wrong choice gives the wrong number of strobes or the wrong half of the burst. It also checks `dout` against the previous word bit by bit, and toggles the clock while deselected to expose a design that shifts when it should not.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

    localparam int FRAME_W = 16;
    localparam int CMD_W   = 4;
    localparam int DATA_W  = FRAME_W - CMD_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic {
        END_ON_CS   = 1'b0,
        END_ON_EDGE = 1'b1
    } end_mode_e;

    // Rising-edge capture for modes 0 and 3, or whenever DSP capture is forced
    function automatic logic capture_on_rise(input logic cpol, input logic cpha,
                                             input logic dsp);
        return dsp | (cpol ~^ cpha);
    endfunction

endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rx_edge.sv
module spi_rx_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic cs_n_s,
    input  logic cap_rise,
    output logic cap_pulse,
    output logic cs_release
);
    logic sclk_prev;
    logic cs_prev;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
        end else begin
            sclk_prev <= sclk_s;
            cs_prev   <= cs_n_s;
        end
    end

    always_comb begin
        rise       = sclk_s & ~sclk_prev;
        fall       = ~sclk_s & sclk_prev;
        cap_pulse  = (cap_rise ? rise : fall) & ~cs_n_s;
        cs_release = cs_n_s & ~cs_prev;
    end

    // R2
    cap_single_chk: assert property (@(posedge clk) disable iff (rst)
        cap_pulse |=> !cap_pulse);
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
    import spi_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  end_mode_e end_mode,
    input  logic      cs_n_s,
    input  logic      din_s,
    input  logic      cap_pulse,
    input  logic      cs_release,
    output logic      frame_done,
    output frame_t    frame_word,
    output logic      msb
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] sh_next;

    assign sh_next = {sh[FRAME_W-2:0], din_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            cnt <= '0;
        end else if (cs_n_s) begin
            cnt <= '0;
        end else if (cap_pulse) begin
            sh <= sh_next;
            if (end_mode == END_ON_EDGE && cnt == LAST) cnt <= '0;
            else if (cnt != FULL)                      cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        frame_done = 1'b0;
        frame_word = frame_t'(sh);
        if (end_mode == END_ON_EDGE) begin
            frame_done = cap_pulse && !cs_n_s && cnt == LAST;
            frame_word = frame_t'(sh_next);
        end else begin
            frame_done = cs_release && cnt == FULL;
        end
    end

    assign msb = sh[FRAME_W-1];

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);
    // R6
    cs_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> cnt == '0);
    // R10
    cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> $stable(sh));
    // R5
    edge_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && end_mode == END_ON_EDGE) |=> cnt == '0);
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_dsp,
    input  logic              cfg_end_mode,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    output logic              frm_valid,
    output logic [CMD_W-1:0]  frm_cmd,
    output logic [DATA_W-1:0] frm_data
);
    logic [2:0] sync_q;
    logic       sclk_s, cs_n_s, din_s;
    logic       cap_pulse, cs_release;
    logic       frame_done;
    frame_t     frame_word;
    frame_t     frame_q;
    logic       valid_q;
    end_mode_e  end_mode;

    assign end_mode = end_mode_e'(cfg_end_mode);

    spi_rx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk, cs_n, din}),
        .q   (sync_q)
    );
    assign {sclk_s, cs_n_s, din_s} = sync_q;

    spi_rx_edge u_edge (
        .clk        (clk),
        .rst        (rst),
        .sclk_s     (sclk_s),
        .cs_n_s     (cs_n_s),
        .cap_rise   (capture_on_rise(cfg_cpol, cfg_cpha, cfg_dsp)),
        .cap_pulse  (cap_pulse),
        .cs_release (cs_release)
    );

    spi_rx_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .end_mode   (end_mode),
        .cs_n_s     (cs_n_s),
        .din_s      (din_s),
        .cap_pulse  (cap_pulse),
        .cs_release (cs_release),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .msb        (dout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            frame_q <= '0;
        end else begin
            valid_q <= frame_done;
            if (frame_done) frame_q <= frame_word;
        end
    end

    assign frm_valid = valid_q;
    assign frm_cmd   = frame_q.cmd;
    assign frm_data  = frame_q.data;

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> !frm_valid);
    // R1
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable({frm_cmd, frm_data}));
endmodule

// File: tb/spi_frame_rx_tb.sv
`timescale 1ns/1ps
module spi_frame_rx_tb;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_cpol = 0, cfg_cpha = 0, cfg_dsp = 0, cfg_end_mode = 0;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic dout, frm_valid;
    logic [3:0]  frm_cmd;
    logic [11:0] frm_data;

    int checks = 0, fails = 0;
    int pulses = 0, hi_cycles = 0;
    logic v_prev = 1'b0;
    logic [15:0] last_word = '0;
    logic dout_log [32];
    logic pre_lvl;
    bit finished = 0;

    always #10 clk = ~clk;

    spi_frame_rx u_dut (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_dsp(cfg_dsp), .cfg_end_mode(cfg_end_mode), .cs_n(cs_n),
        .sclk(sclk), .din(din), .dout(dout), .frm_valid(frm_valid),
        .frm_cmd(frm_cmd), .frm_data(frm_data)
    );

    always @(negedge clk) begin
        if (frm_valid) begin
            hi_cycles++;
            last_word = {frm_cmd, frm_data};
        end
        if (frm_valid && !v_prev) pulses++;
        v_prev = frm_valid;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] bits, input int n);
        cs_n = 1'b0;
        wclk(4);
        for (int i = 0; i < n; i++) begin
            sclk = pre_lvl;
            din  = bits[n-1-i];
            wclk(H);
            sclk = ~pre_lvl;
            wclk(H);
            dout_log[i] = dout;
        end
        sclk = cfg_cpol;
        wclk(H);
    endtask

    task automatic release_cs();
        cs_n = 1'b1;
        wclk(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wclk(5);
        rst = 1'b0;
        wclk(3);
        // R9: reset state
        chk(frm_valid == 1'b0, "R9 valid", frm_valid, 0);
        chk(dout == 1'b0, "R9 dout", dout, 0);

        for (int idx = 0; idx < 16; idx++) begin
            logic [15:0] a, b, c;
            int p;
            string tag;
            cfg_cpol     = idx[0];
            cfg_cpha     = idx[1];
            cfg_dsp      = idx[2];
            cfg_end_mode = idx[3];
            pre_lvl      = (cfg_dsp | (cfg_cpol ~^ cfg_cpha)) ? 1'b0 : 1'b1;
            sclk         = cfg_cpol;
            tag          = cfg_dsp ? "R1 R3" : "R1 R2";
            wclk(10);
            a = 16'hA5C3 ^ 16'(idx * 16'h1357);
            b = ~a ^ 16'h0F0F;
            c = a ^ 16'h3C3C;

            p = pulses;
            send({16'h0, a}, 16);
            if (cfg_end_mode) chk(pulses == p + 1, "R5 strobe before cs", pulses - p, 1);
            else              chk(pulses == p, "R4 no strobe before cs", pulses - p, 0);
            release_cs();
            chk(pulses == p + 1, "R4 R5 one strobe", pulses - p, 1);
            chk(last_word == a, tag, last_word, a);

            send({16'h0, b}, 16);
            for (int k = 0; k < 15; k++)
                chk(dout_log[k] == a[14-k], "R7 chain", dout_log[k], a[14-k]);
            release_cs();
            chk(last_word == b, tag, last_word, b);

            p = pulses;
            send({16'h0, ~b}, 7);
            release_cs();
            chk(pulses == p, "R6 partial dropped", pulses - p, 0);
            send({16'h0, c}, 16);
            release_cs();
            chk(last_word == c, "R6 count restarted", last_word, c);

            // R10: clock activity with chip select high
            p = pulses;
            for (int t = 0; t < 6; t++) begin
                sclk = ~sclk;
                din  = ~c[15];
                wclk(H);
            end
            sclk = cfg_cpol;
            wclk(H);
            chk(dout == c[15], "R10 no shift", dout, c[15]);
            chk(pulses == p, "R10 no strobe", pulses - p, 0);

            p = pulses;
            send({b, a}, 32);
            release_cs();
            if (cfg_end_mode) chk(pulses == p + 2, "R5 two frames", pulses - p, 2);
            else              chk(pulses == p + 1, "R4 one frame", pulses - p, 1);
            chk(last_word == a, "R4 R5 last half", last_word, a);
        end

        chk(hi_cycles == pulses, "R8 single cycle", hi_cycles, pulses);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule